// File: doc/BRIEF.md
# Power-Down Controller

This block sequences a small microcontroller into and out of a deep sleep state in which the core clock is halted. A sleep request from the instruction decoder does not stop the oscillator at once. The controller first waits for the requesting instruction to retire, so that this instruction is the final one executed. Only then does it drop the oscillator/clock enable. While asleep, the on-chip RAM and the special-function registers keep their contents. RAM writes are blocked in every state other than normal running.

Sleep ends only through the asynchronous hardware reset input. Requests, instruction completions and RAM write attempts arriving during sleep have no effect. When reset is asserted, the oscillator enable returns at once. A synchronized copy of the reset holds the sequencer until its release. After release, a settling counter lets the restarted oscillator stabilise. When the count is complete, the controller issues a one-cycle reinitialisation pulse to the special-function registers and then raises `ready`. RAM is never written during any of these steps.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `hw_rst` is high: `ready` = 0, `ram_we` = 0, `osc_en` = 1, `ram_retain` = 1 and `sfr_init` = 0.
- R2: In running mode (`ready` = 1), a cycle with `pd_req` = 1 makes `ready` fall at the next rising edge. The oscillator stays enabled (`osc_en` = 1) while the controller waits for the instruction to retire.
- R3: While waiting, `osc_en` falls at the first rising edge that samples `insn_done` = 1. It does not fall before that edge.
- R4: After `osc_en` has fallen, any pattern of `pd_req`, `insn_done` and `ram_we_req` leaves `osc_en` = 0, `ready` = 0 and `ram_we` = 0 until `hw_rst` is asserted.
- R5: Asserting `hw_rst` in any state sets `osc_en` = 1 and `ready` = 0 without waiting for a clock edge.
- R6: After `hw_rst` falls between two rising edges, `ready` first reads 1 after rising edge number SYNC_STAGES + STAB_CYCLES + 1 counted from that release. This holds whatever the length of the preceding reset.
- R7: Asserting `hw_rst` again before `ready` has risen restarts the full settling delay of R6, counted from the new release.
- R8: `sfr_init` is high for exactly one cycle: the cycle just before `ready` rises.
- R9: `ram_we` equals `ram_we_req` when `ready` = 1 and is 0 in every other state.
- R10: `ram_retain` is 1 exactly when `ready` is 0.
- R11: `insn_done` without a preceding `pd_req` has no effect in running mode. A repeated `pd_req` while waiting for retirement does not move the controller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| hw_rst | input | 1 | Asynchronous hardware reset, active high |
| pd_req | input | 1 | Sleep request from instruction decode |
| insn_done | input | 1 | Current instruction has retired |
| ram_we_req | input | 1 | RAM write enable from the core |
| osc_en | output | 1 | Oscillator / core clock enable |
| ram_retain | output | 1 | RAM retention hold |
| ram_we | output | 1 | Gated RAM write enable |
| sfr_init | output | 1 | One-cycle special-function register reinitialisation pulse |
| ready | output | 1 | Core may execute |

## Verification
The hardest situation to reach is a second reset that lands inside the settling window. At that point the counter is part way through a count and the synchronizer has already released. The bench sets this up by releasing reset, waiting a fixed number of edges while checking that `ready` stays low, and then pulsing `hw_rst` again. It then checks that the full latency is counted from the second release. The bench also sweeps the retirement delay and the reset hold length over small ranges, and computes the expected release edge from the two parameters.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_ENTER   = 2'd1,
    ST_DOWN    = 2'd2,
    ST_RESTART = 2'd3
  } pd_state_e;

  // Next state of the sleep sequencer; the exit from DOWN is the async reset.
  function automatic pd_state_e pd_next(input pd_state_e cur, input logic req,
                                        input logic retired, input logic settle_ok);
    pd_state_e nx;
    nx = cur;
    unique case (cur)
      ST_RUN:     if (req) nx = ST_ENTER;
      ST_ENTER:   if (retired) nx = ST_DOWN;
      ST_DOWN:    nx = ST_DOWN;
      ST_RESTART: if (settle_ok) nx = ST_RUN;
      default:    nx = ST_RESTART;
    endcase
    return nx;
  endfunction

  // Edges from reset release until ready reads high.
  function automatic int unsigned ready_latency(input int unsigned sync_n,
                                                input int unsigned stab_n);
    return sync_n + stab_n + 1;
  endfunction

endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= 1'b1;
        else      chain <= 1'b0;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= '1;
        else      chain <= {chain[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/pwrdn_stab_cnt.sv
module pwrdn_stab_cnt #(
  parameter int STAB_CYCLES = 1024
) (
  input  logic clk,
  input  logic arst,
  input  logic clear,
  output logic done
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)       cnt <= '0;
    else if (clear) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
(
  input  logic      clk,
  input  logic      arst,
  input  logic      rst_q,
  input  logic      pd_req,
  input  logic      insn_done,
  input  logic      stab_done,
  output pd_state_e state,
  output logic      leave_restart
);
  pd_state_e state_nx;

  assign leave_restart = (state == ST_RESTART) && !rst_q && stab_done;

  always_comb begin
    state_nx = pd_next(state, pd_req, insn_done, leave_restart);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) state <= ST_RESTART;
    else      state <= state_nx;
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYCLES = 1024
) (
  input  logic clk,
  input  logic hw_rst,
  input  logic pd_req,
  input  logic insn_done,
  input  logic ram_we_req,
  output logic osc_en,
  output logic ram_retain,
  output logic ram_we,
  output logic sfr_init,
  output logic ready
);
  pd_state_e state;
  logic      rst_q;
  logic      stab_done;
  logic      leave_restart;
  logic      cnt_clear;

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .arst  (hw_rst),
    .rst_q (rst_q)
  );

  assign cnt_clear = rst_q || (state != ST_RESTART);

  pwrdn_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_cnt (
    .clk   (clk),
    .arst  (hw_rst),
    .clear (cnt_clear),
    .done  (stab_done)
  );

  pwrdn_fsm u_fsm (
    .clk           (clk),
    .arst          (hw_rst),
    .rst_q         (rst_q),
    .pd_req        (pd_req),
    .insn_done     (insn_done),
    .stab_done     (stab_done),
    .state         (state),
    .leave_restart (leave_restart)
  );

  assign ready      = (state == ST_RUN);
  assign osc_en     = (state != ST_DOWN);
  assign ram_retain = !ready;
  assign ram_we     = ram_we_req && ready;
  assign sfr_init   = leave_restart;
endmodule

module pwrdn_ctrl_chk (
  input logic clk,
  input logic hw_rst,
  input logic insn_done,
  input logic osc_en,
  input logic ram_retain,
  input logic ram_we,
  input logic sfr_init,
  input logic ready,
  input logic stab_done
);
  AST_WE_ONLY_RUN: assert property (@(posedge clk) disable iff (hw_rst)
    ram_we |-> ready); // R9
  AST_RETAIN_INVERSE: assert property (@(posedge clk) disable iff (hw_rst)
    ready |-> !ram_retain); // R10
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (hw_rst)
    !osc_en |=> !osc_en); // R4
  AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (hw_rst)
    !osc_en |-> (!ready && !ram_we)); // R4
  AST_STOP_AFTER_RETIRE: assert property (@(posedge clk) disable iff (hw_rst)
    $fell(osc_en) |-> $past(insn_done)); // R3
  AST_INIT_THEN_READY: assert property (@(posedge clk) disable iff (hw_rst)
    sfr_init |=> ready); // R8
  AST_INIT_SINGLE: assert property (@(posedge clk) disable iff (hw_rst)
    sfr_init |=> !sfr_init); // R8
  AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (hw_rst)
    $rose(ready) |-> ($past(stab_done) && $past(sfr_init))); // R6
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
  .clk        (clk),
  .hw_rst     (hw_rst),
  .insn_done  (insn_done),
  .osc_en     (osc_en),
  .ram_retain (ram_retain),
  .ram_we     (ram_we),
  .sfr_init   (sfr_init),
  .ready      (ready),
  .stab_done  (stab_done)
);

// File: tb/pwrdn_ctrl_bench.sv
`timescale 1ns/1ps
module pwrdn_ctrl_bench;
  localparam int SYNC_B = 2;
  localparam int STAB_B = 12;
  localparam int LAT    = SYNC_B + STAB_B + 1;

  logic clk = 1'b0;
  logic hw_rst, pd_req, insn_done, ram_we_req;
  logic osc_en, ram_retain, ram_we, sfr_init, ready;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pwrdn_ctrl #(.SYNC_STAGES(SYNC_B), .STAB_CYCLES(STAB_B)) u_pwrdn_ctrl (
    .clk        (clk),
    .hw_rst     (hw_rst),
    .pd_req     (pd_req),
    .insn_done  (insn_done),
    .ram_we_req (ram_we_req),
    .osc_en     (osc_en),
    .ram_retain (ram_retain),
    .ram_we     (ram_we),
    .sfr_init   (sfr_init),
    .ready      (ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // hw_rst is low from the current negedge; walk the edges after release
  task automatic count_release(input string tag);
    for (int n = 1; n <= LAT + 3; n++) begin
      @(negedge clk);
      chk({tag, " R6 ready"},      ready,      n >= LAT);
      chk({tag, " R8 sfr_init"},   sfr_init,   n == LAT - 1);
      chk({tag, " R10 retain"},    ram_retain, n < LAT);
      chk({tag, " R5 osc_en"},     osc_en,     1'b1);
    end
  endtask

  task automatic reset_pulse(input int hold, input string tag);
    @(negedge clk);
    hw_rst = 1'b1;
    #1;
    chk({tag, " R5 async ready"}, ready,  1'b0);
    chk({tag, " R5 async osc"},   osc_en, 1'b1);
    chk({tag, " R1 we"},          ram_we, 1'b0);
    repeat (hold) @(negedge clk);
    hw_rst = 1'b0;
    count_release(tag);
  endtask

  task automatic enter_wait(input int delay);
    @(negedge clk);
    pd_req = 1'b1; ram_we_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    chk("R2 ready falls", ready,      1'b0);
    chk("R2 osc kept",    osc_en,     1'b1);
    chk("R9 we gated",    ram_we,     1'b0);
    chk("R10 retain",     ram_retain, 1'b1);
    for (int k = 0; k < delay; k++) begin
      pd_req = 1'b1;
      @(negedge clk);
      chk("R3 osc before retire", osc_en, 1'b1);
      chk("R11 re-request",       ready,  1'b0);
    end
    pd_req = 1'b0;
    ram_we_req = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    hw_rst = 1'b1; pd_req = 1'b0; insn_done = 1'b0; ram_we_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready",    ready,      1'b0);
    chk("R1 osc",      osc_en,     1'b1);
    chk("R1 retain",   ram_retain, 1'b1);
    chk("R1 we",       ram_we,     1'b0);
    chk("R1 sfr_init", sfr_init,   1'b0);
    ram_we_req = 1'b0;
    hw_rst = 1'b0;
    count_release("power-on");

    // write enable passes through while running
    ram_we_req = 1'b1; #1;
    chk("R9 we pass", ram_we, 1'b1);
    ram_we_req = 1'b0; #1;
    chk("R9 we idle", ram_we, 1'b0);

    // retirement alone does nothing in running mode
    insn_done = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R11 run ready", ready,  1'b1);
      chk("R11 run osc",   osc_en, 1'b1);
    end
    insn_done = 1'b0;

    for (int d = 0; d <= 4; d++) begin
      for (int h = 1; h <= 3; h++) begin
        enter_wait(d);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk("R3 osc stops", osc_en, 1'b0);
        for (int k = 0; k < 8; k++) begin
          pd_req = k[0]; insn_done = k[1]; ram_we_req = k[2];
          @(negedge clk);
          chk("R4 osc held", osc_en, 1'b0);
          chk("R4 ready",    ready,  1'b0);
          chk("R4 we",       ram_we, 1'b0);
        end
        pd_req = 1'b0; insn_done = 1'b0; ram_we_req = 1'b0;
        reset_pulse(h, "exit");
      end
    end

    // reset while waiting for retirement, and while running
    enter_wait(2);
    reset_pulse(1, "enter-reset");
    reset_pulse(4, "run-reset");

    // second reset inside the settling window
    @(negedge clk);
    hw_rst = 1'b1;
    @(negedge clk);
    hw_rst = 1'b0;
    for (int n = 1; n <= LAT - 4; n++) begin
      @(negedge clk);
      chk("R7 still settling", ready, 1'b0);
    end
    reset_pulse(1, "R7 restart");

    summary();
  end
endmodule